// File: doc/BRIEF.md
# CAN Single-Filter Acceptance Check

This block decides whether a CAN frame that the receiver has finished decoding should be kept. Software loads a 32-bit acceptance code and a 32-bit acceptance mask one byte at a time. When the decoder presents a completed frame with a one-cycle strobe, the block packs the frame fields into a 32-bit comparison word. The packing depends on whether the frame uses the standard or the extended identifier format.

Each bit of the comparison word is checked against the matching code bit unless the mask marks it as don't-care. Bits that carry no information for the frame at hand are never checked. These are padding positions and data bytes the frame did not deliver. One cycle after the strobe the block raises a valid pulse together with the accept verdict. The receive buffer uses the verdict to keep or drop the frame.

The asynchronous active-low reset is released through a two-stage synchronizer. Register writes and frame strobes are honoured only once that release has passed.

Top module: `can_accept_filter`

## Requirements
- R1: Byte writes: address values 0 to 3 load code bytes and 4 to 7 load mask bytes. The byte at offset k within each group holds word bits [31-8k:24-8k], so offset 0 holds the most significant byte. A write is used for frames strobed in any later cycle.
- R2: After reset the code reads as all zeros and the mask as all ones, so every frame is accepted. acc_valid and acc_hit are 0 until the first strobe.
- R3: acc_valid is high for exactly the one cycle after a cycle with frm_valid high, and low otherwise.
- R4: acc_hit is 0 in every cycle where acc_valid is 0.
- R5: A mask bit of 1 makes its word bit don't-care. A mask bit of 0 requires the packed bit to equal the code bit. acc_hit is 1 only when no checked bit differs.
- R6: Standard frame (frm_ext = 0), word layout:
  - bits [31:21] hold ID[10:0] and bit 20 holds RTR;
  - bits [19:16] are never checked;
  - bits [15:8] hold the first data byte and bits [7:0] the second;
  - identifier inputs above bit 10 have no effect.
- R7: Standard frame, data bytes:
  - the first data byte is checked only when RTR = 0 and DLC ≥ 1;
  - the second data byte is checked only when RTR = 0 and DLC ≥ 2;
  - an unchecked byte counts as matching whatever its value.
- R8: Extended frame (frm_ext = 1), word layout:
  - bits [31:3] hold ID[28:0] and bit 2 holds RTR;
  - bits [1:0] are never checked;
  - data bytes have no effect.
- R9: A code or mask write in the same cycle as frm_valid does not change the verdict of that frame; the frame uses the values held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Byte write strobe for code/mask |
| reg_addr | input | 3 | Byte select: 0-3 code, 4-7 mask |
| reg_wdata | input | 8 | Byte write data |
| frm_valid | input | 1 | One-cycle strobe: frame fields are valid |
| frm_ext | input | 1 | 1 = extended identifier format |
| frm_id | input | 29 | Identifier, standard uses bits [10:0] |
| frm_rtr | input | 1 | Remote request bit |
| frm_dlc | input | 4 | Data length code |
| frm_data0 | input | 8 | First data byte |
| frm_data1 | input | 8 | Second data byte |
| acc_valid | output | 1 | Verdict valid pulse |
| acc_hit | output | 1 | Frame accepted |

## Verification
The bench aims at the packing boundaries: DLC of 0, 1 and 2, remote standard frames carrying garbage data, and the padding bits of both formats. A design that always compared both data bytes would reject short or remote frames whose data pins disagree with the code. Flipping a single identifier bit under an exact-match mask must reject, which exposes a layout shifted by one position or a swapped byte order in the registers. A write landing in the strobe cycle probes whether the verdict is registered from the old settings. Random frames are drawn with codes near their own packed word, so both verdicts occur often.

// File: rtl/can_accept_filter_pkg.sv
package can_accept_filter_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NUM_BYTES = 4;
  localparam int unsigned WORD_W    = BYTE_W * NUM_BYTES;
  localparam int unsigned STD_ID_W  = 11;
  localparam int unsigned EXT_ID_W  = 29;
  localparam int unsigned DLC_W     = 4;

  typedef struct packed {
    logic                ext;
    logic [EXT_ID_W-1:0] id;
    logic                rtr;
    logic [DLC_W-1:0]    dlc;
    logic [BYTE_W-1:0]   d0;
    logic [BYTE_W-1:0]   d1;
  } rx_frame_t;
endpackage

// File: rtl/caf_regs.sv
module caf_regs
  import can_accept_filter_pkg::*;
#(
  parameter int unsigned ADDR_W = $clog2(2 * NUM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [WORD_W-1:0] code_w,
  output logic [WORD_W-1:0] mask_w
);
  localparam int unsigned IDX_W = ADDR_W - 1;

  logic              sel_mask;
  logic [IDX_W-1:0]  idx;

  assign sel_mask = addr[ADDR_W-1];
  assign idx      = addr[IDX_W-1:0];

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    localparam int unsigned HI = WORD_W - 1 - i * BYTE_W;
    logic              code_en, mask_en;
    logic [BYTE_W-1:0] code_q, mask_q, code_d, mask_d;

    always_comb begin
      code_en = wr_en && !sel_mask && (idx == IDX_W'(i));
      mask_en = wr_en &&  sel_mask && (idx == IDX_W'(i));
      code_d  = code_en ? wdata : code_q;
      mask_d  = mask_en ? wdata : mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q <= '0;
        mask_q <= '1;
      end else begin
        code_q <= code_d;
        mask_q <= mask_d;
      end
    end

    assign code_w[HI -: BYTE_W] = code_q;
    assign mask_w[HI -: BYTE_W] = mask_q;
  end
endmodule

// File: rtl/caf_pack.sv
module caf_pack
  import can_accept_filter_pkg::*;
(
  input  rx_frame_t         frm,
  output logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] care
);
  localparam int unsigned STD_ID_LSB = WORD_W - STD_ID_W;
  localparam int unsigned STD_RTR    = STD_ID_LSB - 1;
  localparam int unsigned EXT_ID_LSB = WORD_W - EXT_ID_W;
  localparam int unsigned EXT_RTR    = EXT_ID_LSB - 1;

  logic d0_present, d1_present;

  always_comb begin
    d0_present = !frm.rtr && (frm.dlc >= DLC_W'(1));
    d1_present = !frm.rtr && (frm.dlc >= DLC_W'(2));
    word = '0;
    care = '0;
    if (frm.ext) begin
      word[WORD_W-1:EXT_ID_LSB] = frm.id;
      word[EXT_RTR]             = frm.rtr;
      care[WORD_W-1:EXT_RTR]    = '1;
    end else begin
      word[WORD_W-1:STD_ID_LSB]   = frm.id[STD_ID_W-1:0];
      word[STD_RTR]               = frm.rtr;
      word[2*BYTE_W-1:BYTE_W]     = frm.d0;
      word[BYTE_W-1:0]            = frm.d1;
      care[WORD_W-1:STD_RTR]      = '1;
      care[2*BYTE_W-1:BYTE_W]     = {BYTE_W{d0_present}};
      care[BYTE_W-1:0]            = {BYTE_W{d1_present}};
    end
  end
endmodule

// File: rtl/caf_compare.sv
module caf_compare
  import can_accept_filter_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] care,
  input  logic [WORD_W-1:0] code_w,
  input  logic [WORD_W-1:0] mask_w,
  output logic              acc_valid,
  output logic              acc_hit
);
  logic miss;
  logic valid_d, hit_d;
  logic valid_q, hit_q;

  always_comb begin
    miss    = |((word ^ code_w) & care & ~mask_w);
    valid_d = strobe;
    hit_d   = strobe && !miss;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      hit_q   <= hit_d;
    end
  end

  assign acc_valid = valid_q;
  assign acc_hit   = hit_q;
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_accept_filter_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  input  logic        frm_valid,
  input  logic        frm_ext,
  input  logic [28:0] frm_id,
  input  logic        frm_rtr,
  input  logic [3:0]  frm_dlc,
  input  logic [7:0]  frm_data0,
  input  logic [7:0]  frm_data1,
  output logic        acc_valid,
  output logic        acc_hit
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [WORD_W-1:0] code_w, mask_w, word, care;
  rx_frame_t         frm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign frm = '{ext: frm_ext, id: frm_id, rtr: frm_rtr, dlc: frm_dlc,
                 d0: frm_data0, d1: frm_data1};

  caf_regs #(.ADDR_W(3)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .code_w(code_w), .mask_w(mask_w)
  );

  caf_pack u_pack (.frm(frm), .word(word), .care(care));

  caf_compare u_cmp (
    .clk(clk), .rst_n(rst_sync_n), .strobe(frm_valid), .word(word),
    .care(care), .code_w(code_w), .mask_w(mask_w),
    .acc_valid(acc_valid), .acc_hit(acc_hit)
  );
endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        reg_wr_en,
  input logic [2:0]  reg_addr,
  input logic [7:0]  reg_wdata,
  input logic        frm_valid,
  input logic [31:0] code_w,
  input logic [31:0] mask_w,
  input logic        acc_valid,
  input logic        acc_hit
);
  // R3
  pulse_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frm_valid |=> acc_valid);
  // R3
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !frm_valid |=> !acc_valid);
  // R4
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !acc_valid |-> !acc_hit);
  // R1
  code_msb_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr_en && reg_addr == 3'd0) |=> code_w[31:24] == $past(reg_wdata));
  // R1
  mask_lsb_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr_en && reg_addr == 3'd7) |=> mask_w[7:0] == $past(reg_wdata));
  // R5
  open_mask_accepts_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (frm_valid && mask_w == 32'hFFFF_FFFF) |=> acc_hit);
endmodule

bind can_accept_filter can_accept_filter_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .reg_wr_en(reg_wr_en),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .frm_valid(frm_valid),
  .code_w(code_w), .mask_w(mask_w), .acc_valid(acc_valid), .acc_hit(acc_hit)
);

// File: tb/can_accept_filter_test.sv
module can_accept_filter_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        frm_valid = 1'b0;
  logic        frm_ext = 1'b0;
  logic [28:0] frm_id = '0;
  logic        frm_rtr = 1'b0;
  logic [3:0]  frm_dlc = '0;
  logic [7:0]  frm_data0 = '0;
  logic [7:0]  frm_data1 = '0;
  logic        acc_valid, acc_hit;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_code = 32'h0;
  logic [31:0] m_mask = 32'hFFFF_FFFF;

  always #(PERIOD/2) clk = ~clk;

  can_accept_filter uut (.*);

  function automatic logic [31:0] pack_word(logic ext, logic [28:0] id, logic rtr,
                                            logic [7:0] d0, logic [7:0] d1);
    if (ext) return {id, rtr, 2'b00};
    return {id[10:0], rtr, 4'h0, d0, d1};
  endfunction

  function automatic logic [31:0] pack_care(logic ext, logic rtr, logic [3:0] dlc);
    logic a, b;
    if (ext) return 32'hFFFF_FFFC;
    a = !rtr && dlc >= 4'd1;
    b = !rtr && dlc >= 4'd2;
    return {12'hFFF, 4'h0, {8{a}}, {8{b}}};
  endfunction

  function automatic logic model_hit(logic [31:0] code, logic [31:0] mask, logic ext,
                                     logic [28:0] id, logic rtr, logic [3:0] dlc,
                                     logic [7:0] d0, logic [7:0] d1);
    return ((pack_word(ext, id, rtr, d0, d1) ^ code) & pack_care(ext, rtr, dlc) & ~mask) == 0;
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (a[2]) m_mask[31-8*a[1:0] -: 8] = d;
    else      m_code[31-8*a[1:0] -: 8] = d;
  endtask

  task automatic load(logic [31:0] code, logic [31:0] mask);
    for (int i = 0; i < 4; i++) wr(3'(i), code[31-8*i -: 8]);
    for (int i = 0; i < 4; i++) wr(3'(4+i), mask[31-8*i -: 8]);
  endtask

  task automatic frame(string req, logic ext, logic [28:0] id, logic rtr, logic [3:0] dlc,
                       logic [7:0] d0, logic [7:0] d1, logic exp);
    @(negedge clk);
    frm_valid = 1'b1; frm_ext = ext; frm_id = id; frm_rtr = rtr;
    frm_dlc = dlc; frm_data0 = d0; frm_data1 = d1;
    @(negedge clk);
    frm_valid = 1'b0;
    check({req, " valid"}, acc_valid, 1'b1);
    check(req, acc_hit, exp);
    @(negedge clk);
    check("R3 pulse ends", acc_valid, 1'b0);
    check("R4 hit low", acc_hit, 1'b0);
  endtask

  task automatic frame_m(string req, logic ext, logic [28:0] id, logic rtr, logic [3:0] dlc,
                         logic [7:0] d0, logic [7:0] d1);
    frame(req, ext, id, rtr, dlc, d0, d1, model_hit(m_code, m_mask, ext, id, rtr, dlc, d0, d1));
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 valid at reset", acc_valid, 1'b0);
    check("R2 hit at reset", acc_hit, 1'b0);
    // R2: reset mask all ones accepts anything
    frame("R2 open after reset", 1'b0, 29'h1ABCDEF0, 1'b0, 4'd8, 8'h55, 8'hAA, 1'b1);

    // R5 / R6 exact standard match
    w = pack_word(1'b0, 29'h5A3, 1'b0, 8'h12, 8'h34);
    load(w, 32'h0);
    frame("R5 exact std", 1'b0, 29'h5A3, 1'b0, 4'd2, 8'h12, 8'h34, 1'b1);
    frame("R6 id bit0 flip", 1'b0, 29'h5A2, 1'b0, 4'd2, 8'h12, 8'h34, 1'b0);
    frame("R6 id upper ignored", 1'b0, 29'h1FFFF5A3, 1'b0, 4'd2, 8'h12, 8'h34, 1'b1);
    frame("R6 second byte mismatch", 1'b0, 29'h5A3, 1'b0, 4'd2, 8'h12, 8'h35, 1'b0);
    // R7 short and remote frames
    frame("R7 dlc1 ignores byte2", 1'b0, 29'h5A3, 1'b0, 4'd1, 8'h12, 8'hEE, 1'b1);
    frame("R7 dlc1 checks byte1", 1'b0, 29'h5A3, 1'b0, 4'd1, 8'h13, 8'h34, 1'b0);
    frame("R7 dlc0 ignores both", 1'b0, 29'h5A3, 1'b0, 4'd0, 8'hFF, 8'hFF, 1'b1);
    // RTR=1 differs from code bit 20 -> reject; then load code with RTR set
    frame("R6 rtr bit checked", 1'b0, 29'h5A3, 1'b1, 4'd2, 8'h12, 8'h34, 1'b0);
    wr(3'd1, m_code[23:16] | 8'h10);
    frame("R7 remote ignores data", 1'b0, 29'h5A3, 1'b1, 4'd8, 8'h00, 8'h00, 1'b1);
    // R6 padding bits 19:16 never checked
    wr(3'd1, m_code[23:16] ^ 8'h0F);
    frame("R6 padding ignored", 1'b0, 29'h5A3, 1'b1, 4'd0, 8'h00, 8'h00, 1'b1);

    // R8 extended layout
    w = pack_word(1'b1, 29'h0ACE1234, 1'b0, 8'h0, 8'h0) | 32'h3;
    load(w, 32'h0);
    frame("R8 ext exact, low bits ignored", 1'b1, 29'h0ACE1234, 1'b0, 4'd8, 8'h9C, 8'h3D, 1'b1);
    frame("R8 ext id bit28 flip", 1'b1, 29'h1ACE1234, 1'b0, 4'd8, 8'h00, 8'h00, 1'b0);
    frame("R8 ext id bit0 flip", 1'b1, 29'h0ACE1235, 1'b0, 4'd8, 8'h00, 8'h00, 1'b0);
    frame("R8 ext rtr checked", 1'b1, 29'h0ACE1234, 1'b1, 4'd0, 8'h00, 8'h00, 1'b0);
    // R5 mask a flipped bit as don't-care
    wr(3'd7, 8'h08);
    frame("R5 masked bit ignored", 1'b1, 29'h0ACE1235, 1'b0, 4'd8, 8'h00, 8'h00, 1'b1);

    // R9 write in strobe cycle uses old settings
    load(32'h0, 32'h0);
    @(negedge clk);
    frm_valid = 1'b1; frm_ext = 1'b1; frm_id = 29'h1; frm_rtr = 1'b0; frm_dlc = 4'd0;
    reg_wr_en = 1'b1; reg_addr = 3'd7; reg_wdata = 8'hFF;
    @(negedge clk);
    frm_valid = 1'b0; reg_wr_en = 1'b0; m_mask[7:0] = 8'hFF;
    check("R9 valid", acc_valid, 1'b1);
    check("R9 old mask used", acc_hit, 1'b0);
    frame("R9 new mask applied", 1'b1, 29'h1, 1'b0, 4'd0, 8'h00, 8'h00, 1'b1);

    // R1/R5 random, codes near the frame's own word
    for (int n = 0; n < 400; n++) begin
      logic e, r;
      logic [28:0] id;
      logic [3:0] dl;
      logic [7:0] a, b;
      logic [31:0] flip;
      e = 1'($urandom); r = ($urandom % 4) == 0; id = 29'($urandom);
      dl = 4'($urandom % 10); a = 8'($urandom); b = 8'($urandom);
      if (n % 8 == 0) begin
        flip = (($urandom % 2) == 0) ? 32'h0 : (32'h1 << ($urandom % 32));
        load(pack_word(e, id, r, a, b) ^ flip, $urandom & $urandom & $urandom);
      end else if (n % 3 == 0) begin
        id[$urandom % 29] ^= 1'b1;
      end
      frame_m("R1 R5 random", e, id, r, dl, a, b);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule